// File: doc/BRIEF.md
# Dual-Path Registered Bus Transceiver

This block links two W-bit ports, A and B. Each port has its own storage register and its own output stage. Each output direction is switched on by its own enable. The A-to-B enable is active high and the B-to-A enable is active low, so the two ports can be isolated, one of them can be driven, or both can be driven together. An output stage carries either live data from the opposite port or the content of that port's storage register, as chosen by a per-direction source select.

Each port is split into an input bus, an output bus and an output-enable. The register load strobes arrive asynchronously. Each strobe is passed through a two-flop synchroniser and edge-detected in the system-clock domain. On a detected rising edge, a register captures the resolved value of its port. The resolved value is the block's own driven output when that output is enabled, and the external input otherwise. Because of this, a register can be loaded through the looped output path, which copies one port's data into both registers.

A status pulse flags a pair of strobe edges that land in the same cycle while a stored-data select is active. In that case the two registers cannot both be loaded with the intended data.

Top module: `regxcvr_top`

## Requirements
- R1: While `ab_en` is low and `ba_en_n` is high, both `a_oe` and `b_oe` are low from the next clock edge.
- R2: `b_oe` follows `ab_en`, and `a_oe` follows the inverse of `ba_en_n`, each with one cycle of latency. The two are independent, so both can be high together.
- R3: `b_out` is updated every cycle. When `ab_sel` is 0, it takes the resolved A port value. When `ab_sel` is 1, it takes the A register content. Latency is one cycle.
- R4: `a_out` is updated every cycle. When `ba_sel` is 0, it takes the resolved B port value. When `ba_sel` is 1, it takes the B register content. Latency is one cycle.
- R5: With `ab_en`=1, `ba_en_n`=0 and both selects at 1, on the next cycle stored A data appears on `b_out` and stored B data appears on `a_out` at the same time, with both enables high.
- R6: A rising edge on `a_stb` or `b_stb` loads its register whatever the enables are. An edge set up before clock edge k is captured at edge k+2. The register holds at all other times.
- R7: A register captures its resolved port value. When A data is being driven onto B live (`ab_sel`=0) and both strobes fire, both registers end up holding the A data.
- R8: When both strobe edges are detected in the same cycle and `ab_sel` or `ba_sel` is 1, `conflict` is high for exactly one cycle, on the following cycle. It stays low otherwise.
- R9: Synchronous reset clears both registers, both outputs, both enables, the strobe synchronisers and `conflict`.
- R10: When a port's output is not enabled, a capture on that port takes the external input bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | W | External value on port A |
| a_out | output | W | Value the block drives onto port A |
| a_oe | output | 1 | Port A output enable |
| b_in | input | W | External value on port B |
| b_out | output | W | Value the block drives onto port B |
| b_oe | output | 1 | Port B output enable |
| ab_en | input | 1 | A-to-B drive enable, active high |
| ba_en_n | input | 1 | B-to-A drive enable, active low |
| ab_sel | input | 1 | A-to-B source: 0 live, 1 stored |
| ba_sel | input | 1 | B-to-A source: 0 live, 1 stored |
| a_stb | input | 1 | Asynchronous load strobe for the A register |
| b_stb | input | 1 | Asynchronous load strobe for the B register |
| conflict | output | 1 | One-cycle pulse on a coincident stored-mode strobe pair |

## Verification
The assertions assume that the enables and selects are synchronous to `clk` and driven from time zero. The strobe-edge checks also assume that each strobe holds a level for at least two cycles, so that the synchroniser sees every change. The bench changes every input only at the falling clock edge. It holds each strobe high for two cycles and low for at least three. It creates coincident strobe pairs on purpose, both with live selects and with stored selects, to exercise both sides of the conflict rule.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    localparam int XCVR_W    = 8;
    localparam int SYNC_LEN  = 2;

    typedef enum logic {
        SRC_LIVE   = 1'b0,
        SRC_STORED = 1'b1
    } src_e;

    // Coincident capture is unsafe once either path reads a register.
    function automatic logic clash(input logic edge_a, input logic edge_b,
                                   input src_e s_ab, input src_e s_ba);
        return edge_a && edge_b && (s_ab == SRC_STORED || s_ba == SRC_STORED);
    endfunction

endpackage

// File: rtl/xcvr_strobe_sync.sv
module xcvr_strobe_sync #(
    parameter int STAGES = xcvr_pkg::SYNC_LEN
) (
    input  logic clk,
    input  logic rst,
    input  logic stb,
    output logic rise
);
    localparam int LEN = STAGES + 1;

    logic [LEN-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[LEN-2:0], stb};
    end

    assign rise = chain[LEN-2] && !chain[LEN-1];

    // R6
    rise_once_chk: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/xcvr_store.sv
module xcvr_store #(
    parameter int W = xcvr_pkg::XCVR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q));

endmodule

// File: rtl/xcvr_drive.sv
module xcvr_drive #(
    parameter int W          = xcvr_pkg::XCVR_W,
    parameter bit ACTIVE_LOW = 1'b0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  xcvr_pkg::src_e  src,
    input  logic [W-1:0]    live,
    input  logic [W-1:0]    stored,
    output logic [W-1:0]    dout,
    output logic            oe
);
    import xcvr_pkg::*;

    logic oe_next;

    generate
        if (ACTIVE_LOW) begin : g_low
            assign oe_next = !en;
        end else begin : g_high
            assign oe_next = en;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
            oe   <= 1'b0;
        end else begin
            dout <= (src == SRC_STORED) ? stored : live;
            oe   <= oe_next;
        end
    end

endmodule

// File: rtl/regxcvr_top.sv
module regxcvr_top #(
    parameter int W = xcvr_pkg::XCVR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic         b_oe,
    input  logic         ab_en,
    input  logic         ba_en_n,
    input  logic         ab_sel,
    input  logic         ba_sel,
    input  logic         a_stb,
    input  logic         b_stb,
    output logic         conflict
);
    import xcvr_pkg::*;

    localparam int NPORT = 2;

    logic [NPORT-1:0] stb_in;
    logic [NPORT-1:0] edge_seen;
    logic [W-1:0]     bus_a, bus_b;
    logic [W-1:0]     reg_a, reg_b;
    src_e             src_ab, src_ba;

    assign stb_in = {b_stb, a_stb};
    assign src_ab = src_e'(ab_sel);
    assign src_ba = src_e'(ba_sel);

    genvar gi;
    generate
        for (gi = 0; gi < NPORT; gi++) begin : g_sync
            xcvr_strobe_sync u_sync (
                .clk  (clk),
                .rst  (rst),
                .stb  (stb_in[gi]),
                .rise (edge_seen[gi])
            );
        end
    endgenerate

    // resolved port values: own drive wins when enabled
    assign bus_a = a_oe ? a_out : a_in;
    assign bus_b = b_oe ? b_out : b_in;

    xcvr_store #(.W(W)) u_reg_a (
        .clk (clk), .rst (rst), .load (edge_seen[0]), .d (bus_a), .q (reg_a)
    );

    xcvr_store #(.W(W)) u_reg_b (
        .clk (clk), .rst (rst), .load (edge_seen[1]), .d (bus_b), .q (reg_b)
    );

    xcvr_drive #(.W(W), .ACTIVE_LOW(1'b0)) u_drv_ab (
        .clk (clk), .rst (rst), .en (ab_en), .src (src_ab),
        .live (bus_a), .stored (reg_a), .dout (b_out), .oe (b_oe)
    );

    xcvr_drive #(.W(W), .ACTIVE_LOW(1'b1)) u_drv_ba (
        .clk (clk), .rst (rst), .en (ba_en_n), .src (src_ba),
        .live (bus_b), .stored (reg_b), .dout (a_out), .oe (a_oe)
    );

    always_ff @(posedge clk) begin
        if (rst) conflict <= 1'b0;
        else     conflict <= clash(edge_seen[0], edge_seen[1], src_ab, src_ba);
    end

    // R1
    isolate_chk: assert property (@(posedge clk) disable iff (rst)
        (!ab_en && ba_en_n) |=> (!a_oe && !b_oe));

    // R3
    stored_ab_chk: assert property (@(posedge clk) disable iff (rst)
        ab_sel |=> (b_out == $past(reg_a)));

    // R4
    stored_ba_chk: assert property (@(posedge clk) disable iff (rst)
        ba_sel |=> (a_out == $past(reg_b)));

    // R5
    both_stored_chk: assert property (@(posedge clk) disable iff (rst)
        (ab_en && !ba_en_n && ab_sel && ba_sel) |=>
            (a_oe && b_oe && b_out == $past(reg_a) && a_out == $past(reg_b)));

    // R8
    conflict_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        conflict |=> !conflict);

endmodule

// File: tb/sim_regxcvr_top.sv
`timescale 1ns/1ps
module sim_regxcvr_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, b_out;
    logic         a_oe, b_oe, conflict;
    logic         ab_en = 1'b0, ba_en_n = 1'b1, ab_sel = 1'b0, ba_sel = 1'b0;
    logic         a_stb = 1'b0, b_stb = 1'b0;

    int checks = 0;
    int errors = 0;
    int conf_cnt = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    regxcvr_top #(.W(W)) u0 (
        .clk(clk), .rst(rst), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe), .ab_en(ab_en),
        .ba_en_n(ba_en_n), .ab_sel(ab_sel), .ba_sel(ba_sel),
        .a_stb(a_stb), .b_stb(b_stb), .conflict(conflict)
    );

    // behavioural reference
    logic [W-1:0] m_ra = '0, m_rb = '0, m_ao = '0, m_bo = '0;
    logic         m_aoe = 0, m_boe = 0, m_conf = 0;
    logic [2:0]   m_sa = '0, m_sb = '0;

    always @(posedge clk) begin
        logic [W-1:0] va, vb;
        logic         ea, eb;
        if (rst) begin
            m_ra = '0; m_rb = '0; m_ao = '0; m_bo = '0;
            m_aoe = 0; m_boe = 0; m_conf = 0; m_sa = '0; m_sb = '0;
        end else begin
            va = m_aoe ? m_ao : a_in;
            vb = m_boe ? m_bo : b_in;
            ea = m_sa[1] & ~m_sa[2];
            eb = m_sb[1] & ~m_sb[2];
            m_conf = ea && eb && (ab_sel || ba_sel);
            m_bo = ab_sel ? m_ra : va;
            m_ao = ba_sel ? m_rb : vb;
            m_boe = ab_en;
            m_aoe = !ba_en_n;
            if (ea) m_ra = va;
            if (eb) m_rb = vb;
            m_sa = {m_sa[1:0], a_stb};
            m_sb = {m_sb[1:0], b_stb};
        end
    end

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        cycles++;
        conf_cnt += int'(conflict);
        if (!rst) begin
            chk("R2 b_oe", W'(b_oe), W'(m_boe));
            chk("R2 a_oe", W'(a_oe), W'(m_aoe));
            chk("R3 b_out", b_out, m_bo);
            chk("R4 a_out", a_out, m_ao);
            chk("R8 conflict", W'(conflict), W'(m_conf));
        end
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse(input logic do_a, input logic do_b);
        a_stb = do_a; b_stb = do_b;
        step(2);
        a_stb = 0; b_stb = 0;
        step(3);
    endtask

    initial begin
        step(3);
        // R9
        chk("R9 a_out", a_out, '0);
        chk("R9 b_out", b_out, '0);
        chk("R9 oe", W'({a_oe, b_oe, conflict}), '0);
        rst = 0;

        // R1 isolation
        step(2);
        chk("R1 oe", W'({a_oe, b_oe}), '0);

        // R6 capture with both paths off
        a_in = 8'h3C;
        pulse(1, 0);
        ab_en = 1; ab_sel = 1;
        step(1);
        chk("R6 b_out", b_out, 8'h3C);
        chk("R2 b_oe", W'(b_oe), 8'h01);
        ab_sel = 0; a_in = 8'h55;
        step(1);
        chk("R3 live", b_out, 8'h55);

        // R10 capture of external B input while B undriven
        ab_en = 0; b_in = 8'hA7;
        step(1);
        pulse(0, 1);
        ab_en = 1; ab_sel = 1; ba_en_n = 0; ba_sel = 1;
        step(1);
        chk("R10 a_out", a_out, 8'hA7);
        chk("R5 b_out", b_out, 8'h3C);
        chk("R5 oe", W'({a_oe, b_oe}), 8'h03);

        // R7 loop copy: A live onto B, both strobes together
        ba_en_n = 1; ba_sel = 0; ab_sel = 0; a_in = 8'h91; b_in = 8'h00;
        step(2);
        conf_cnt = 0;
        pulse(1, 1);
        chk("R8 no conflict live", W'(conf_cnt), '0);
        ab_sel = 1; ba_en_n = 0; ba_sel = 1;
        step(1);
        chk("R7 reg_a", b_out, 8'h91);
        chk("R7 reg_b", a_out, 8'h91);

        // R8 coincident strobes in stored mode
        conf_cnt = 0;
        pulse(1, 1);
        step(2);
        chk("R8 conflict count", W'(conf_cnt), 8'h01);

        // R1 again after activity
        ab_en = 0; ba_en_n = 1;
        step(1);
        chk("R1 oe late", W'({a_oe, b_oe}), '0);
        step(4);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule